// File: doc/BRIEF.md
# UART Line Status Register with Error-Tagged Receive FIFO

This block is the status side of a UART-style serial port. It holds received characters in a small queue, where each character keeps its own parity, framing and break flags, and it presents an 8-bit line status value to the host. It also returns the character at the head of the queue, and it raises a line-status interrupt and a transmit-empty interrupt. The receiver pushes characters with their error flags. The transmit path reports whether its holding stage and its shift stage are empty. The host issues three strobes: status read, receive-buffer read and transmit write.

Two modes are supported. In holding mode the receive buffer holds one character. In FIFO mode it holds `DEPTH` characters. In FIFO mode an error becomes visible in the status bits only when its character reaches the head of the queue. A summary bit shows whether any errored character is still queued. The error bits clear when the host reads the status. The summary bit clears on a status read only once no errored entry remains. The mode is assumed to change only while the receive queue is empty.

Top module: `uart_line_status`

## Requirements
- R1: After reset, with both transmit stages reporting empty, `lsr_q` is 0x60, `rbr_q` is 0 and both interrupts are low.
- R2: Bit 0 (data ready) is 1 from the cycle after a character is accepted. It stays 1 while any character is buffered and is 0 after the last one is read through `rbr_rd`.
- R3: Characters leave in the order they were accepted. `rbr_q` shows the head character, or 0 when the buffer is empty. Capacity is `DEPTH` (16) entries in FIFO mode and 1 in holding mode.
- R4: A push while the buffer is full and not read in the same cycle is dropped. The buffer contents and every status bit are unchanged.
- R5: Bit 2 (parity), bit 3 (framing) and bit 4 (break) are set when a character carrying that flag becomes the head. In holding mode this happens on the cycle of the push. In FIFO mode it happens when the earlier characters have been read.
- R6: A status read (`lsr_rd`) clears bits 4 to 1, unless a flagged character becomes the head in the same cycle.
- R7: Bit 1 (overrun) always reads 0.
- R8: In FIFO mode, bit 7 is 1 while any queued entry carries an error flag. Once set, it stays 1 until a status read made when no errored entry remains. In holding mode it is always 0.
- R9: Bit 5 (holding empty) is 1 when the transmit path reports its holding stage empty and no host write is still unacknowledged. It is 0 from the cycle after `thr_wr`.
- R10: Bit 6 (transmitter empty) is 1 only when bit 5 is 1 and the transmit shift stage is empty. It is 0 from the cycle after `thr_wr`.
- R11: `ls_irq` is 1 exactly when `ls_irq_en` is set and any of bits 4 to 1 is 1.
- R12: `thre_irq` pulses high for one cycle when bit 5 rises from 0 to 1 while `thre_irq_en` is set. It does not pulse when the enable is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fifo_mode | input | 1 | 1 selects FIFO mode, 0 selects holding mode |
| lsr_rd | input | 1 | Host reads the line status value this cycle |
| rbr_rd | input | 1 | Host reads the receive buffer this cycle (pops the head) |
| thr_wr | input | 1 | Host writes a transmit byte this cycle |
| rx_push | input | 1 | Receiver delivers a character |
| rx_data | input | 8 | Received character |
| rx_par_err | input | 1 | Parity error flag of the delivered character |
| rx_frm_err | input | 1 | Framing error flag of the delivered character |
| rx_brk | input | 1 | Break flag of the delivered character |
| tx_hold_empty | input | 1 | Transmit holding register or FIFO is empty |
| tx_shift_empty | input | 1 | Transmit shift register is empty |
| ls_irq_en | input | 1 | Line-status interrupt enable |
| thre_irq_en | input | 1 | Holding-empty interrupt enable |
| lsr_q | output | 8 | Line status value |
| rbr_q | output | 8 | Character at the head of the receive buffer |
| ls_irq | output | 1 | Line-status interrupt request |
| thre_irq | output | 1 | One-cycle holding-empty interrupt pulse |

## Verification
The FIFO-mode vector walk queues clean and flagged characters behind one another. This shows that an error is shown at the head rather than at the push, and that the summary bit lingers after its entry leaves but the per-character bits do not. Simultaneous push-and-pop and read-and-pop rows separate the arrival path for an empty queue from the path that promotes an older entry. A fill to capacity followed by a flagged extra push confirms that a dropped character leaves no trace in the data or the status. Holding-mode pushes show immediate flag reporting with the summary bit held at 0. A transmit write followed by staged release of the holding and shift stages separates the two empty bits and the single interrupt pulse.

// File: rtl/lsr_pkg.sv
// Shared types for the line status block.
// Holds the receive entry layout (character plus three error tags) and the
// bit positions of the status value, which host software decodes.
package lsr_pkg;
    localparam int DATA_W = 8;

    typedef struct packed {
        logic              brk;
        logic              frm;
        logic              par;
        logic [DATA_W-1:0] data;
    } rx_entry_t;

    localparam int B_DR    = 0;
    localparam int B_OE    = 1;
    localparam int B_PE    = 2;
    localparam int B_FE    = 3;
    localparam int B_BI    = 4;
    localparam int B_THRE  = 5;
    localparam int B_TEMT  = 6;
    localparam int B_RXERR = 7;

    // True when an entry carries any error tag.
    function automatic logic entry_bad(input rx_entry_t e);
        return e.brk | e.frm | e.par;
    endfunction
endpackage

// File: rtl/lsr_rx_fifo.sv
// Receive queue whose entries carry their own error tags.
// Does: stores up to DEPTH entries (1 in holding mode), counts queued errored
//       entries, and reports which entry becomes the head in a given cycle.
// Assumes: fifo_mode changes only while the queue is empty; a push into a
//          full queue is accepted only if a pop frees a slot in that cycle.
module lsr_rx_fifo
    import lsr_pkg::*;
#(
    parameter  int DEPTH = 16,
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fifo_mode,
    input  logic          push,
    input  rx_entry_t     push_ent,
    input  logic          pop_req,
    output rx_entry_t     head_ent,
    output logic [CW-1:0] count,
    output logic [CW-1:0] err_cnt,
    output logic          arr_valid,
    output rx_entry_t     arr_ent
);
    logic [AW-1:0] rd_ptr, wr_ptr;
    logic [CW-1:0] cap;
    logic          full, pop_ok, push_ok, push_bad, pop_bad;
    rx_entry_t     slot_rd [DEPTH];

    // Next pointer with wrap for any depth.
    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    assign cap      = fifo_mode ? CW'(DEPTH) : CW'(1);
    assign full     = (count >= cap);
    assign pop_ok   = pop_req && (count != '0);
    assign push_ok  = push && (!full || pop_ok);
    assign head_ent = (count != '0) ? slot_rd[rd_ptr] : '0;
    assign push_bad = push_ok && entry_bad(push_ent);
    assign pop_bad  = pop_ok && entry_bad(head_ent);

    // One storage slot per entry, written when the write pointer selects it.
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        rx_entry_t slot_q;
        always_ff @(posedge clk) begin  // capture pushed entry
            if (push_ok && wr_ptr == AW'(g)) slot_q <= push_ent;
        end
        assign slot_rd[g] = slot_q;
    end

    // Work out which entry, if any, becomes the head at this edge.
    always_comb begin
        arr_valid = 1'b0;
        arr_ent   = '0;
        if (push_ok && (count == '0 || (pop_ok && count == CW'(1)))) begin
            arr_valid = 1'b1;
            arr_ent   = push_ent;
        end else if (pop_ok && count > CW'(1)) begin
            arr_valid = 1'b1;
            arr_ent   = slot_rd[bump(rd_ptr)];
        end
    end

    // Pointer, occupancy and errored-entry count update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr  <= '0;
            wr_ptr  <= '0;
            count   <= '0;
            err_cnt <= '0;
        end else begin
            if (push_ok) wr_ptr <= bump(wr_ptr);
            if (pop_ok)  rd_ptr <= bump(rd_ptr);
            count   <= count + CW'(push_ok) - CW'(pop_ok);
            err_cnt <= err_cnt + CW'(push_bad) - CW'(pop_bad);
        end
    end

    // R3
    cap_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));
    // R4
    drop_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop_req) |=> $stable(count) && $stable(err_cnt));
    // R8
    err_le_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_cnt <= count);
endmodule

// File: rtl/lsr_err_flags.sv
// Sticky error bits of the line status value.
// Does: latches parity, framing and break tags of each entry as it becomes the
//       head, clears them on a status read, and keeps the queue-wide error
//       summary until a read finds no errored entry queued.
// Assumes: arr_valid/arr_ent come from the receive queue in the same cycle.
module lsr_err_flags
    import lsr_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      fifo_mode,
    input  logic      rd_lsr,
    input  logic      arr_valid,
    input  rx_entry_t arr_ent,
    input  logic      err_held,
    output logic      pe,
    output logic      fe,
    output logic      bi,
    output logic      rx_err
);
    logic sum_hold;

    // Sticky head flags: set on arrival, cleared by a status read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pe <= 1'b0;
            fe <= 1'b0;
            bi <= 1'b0;
        end else begin
            pe <= (pe && !rd_lsr) || (arr_valid && arr_ent.par);
            fe <= (fe && !rd_lsr) || (arr_valid && arr_ent.frm);
            bi <= (bi && !rd_lsr) || (arr_valid && arr_ent.brk);
        end
    end

    // Summary hold: kept while errors are queued or until the next read.
    always_ff @(posedge clk) begin
        if (!rst_n) sum_hold <= 1'b0;
        else        sum_hold <= fifo_mode && (err_held || (sum_hold && !rd_lsr));
    end

    assign rx_err = fifo_mode && (err_held || sum_hold);

    // R6
    rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_lsr && !arr_valid) |=> !pe && !fe && !bi);
    // R5
    head_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_valid && arr_ent.par) |=> pe);
    // R8
    hold_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_mode |-> !rx_err);
endmodule

// File: rtl/lsr_tx_track.sv
// Transmit-empty bits and the holding-empty interrupt pulse.
// Does: hides the holding-empty report from the transmit path until that path
//       has taken a host write, derives transmitter empty, and pulses an
//       interrupt when holding-empty rises.
// Assumes: the transmit path drops hold_empty at some point after a write.
module lsr_tx_track (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_thr,
    input  logic hold_empty,
    input  logic shift_empty,
    input  logic thre_ien,
    output logic thre,
    output logic temt,
    output logic irq_thre
);
    logic wr_pend, thre_prev;

    // Pending write: set by the host, cleared once the path shows it is busy.
    always_ff @(posedge clk) begin
        if (!rst_n)          wr_pend <= 1'b0;
        else if (wr_thr)     wr_pend <= 1'b1;
        else if (!hold_empty) wr_pend <= 1'b0;
    end

    // Previous holding-empty value for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) thre_prev <= 1'b1;
        else        thre_prev <= thre;
    end

    assign thre     = hold_empty && !wr_pend;
    assign temt     = thre && shift_empty;
    assign irq_thre = thre_ien && thre && !thre_prev;

    // R9
    wr_thre_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_thr |=> !thre);
    // R10
    wr_temt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_thr |=> !temt);
    // R12
    irq_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_thre |=> !irq_thre);
endmodule

// File: rtl/uart_line_status.sv
// Line status register with an error-tagged receive queue.
// Does: joins the receive queue, sticky error bits and transmit-empty logic
//       into the host-visible status byte and the two interrupt requests.
// Assumes: strobes are single-cycle; fifo_mode changes only when empty.
module uart_line_status
    import lsr_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fifo_mode,
    input  logic              lsr_rd,
    input  logic              rbr_rd,
    input  logic              thr_wr,
    input  logic              rx_push,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rx_par_err,
    input  logic              rx_frm_err,
    input  logic              rx_brk,
    input  logic              tx_hold_empty,
    input  logic              tx_shift_empty,
    input  logic              ls_irq_en,
    input  logic              thre_irq_en,
    output logic [7:0]        lsr_q,
    output logic [DATA_W-1:0] rbr_q,
    output logic              ls_irq,
    output logic              thre_irq
);
    localparam int CW = $clog2(DEPTH + 1);

    rx_entry_t     push_ent, head_ent, arr_ent;
    logic [CW-1:0] count, err_cnt;
    logic          arr_valid, pe, fe, bi, rx_err, thre, temt;

    assign push_ent = '{brk: rx_brk, frm: rx_frm_err, par: rx_par_err, data: rx_data};

    lsr_rx_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .fifo_mode(fifo_mode),
        .push(rx_push), .push_ent(push_ent), .pop_req(rbr_rd),
        .head_ent(head_ent), .count(count), .err_cnt(err_cnt),
        .arr_valid(arr_valid), .arr_ent(arr_ent)
    );

    lsr_err_flags u_flags (
        .clk(clk), .rst_n(rst_n), .fifo_mode(fifo_mode), .rd_lsr(lsr_rd),
        .arr_valid(arr_valid), .arr_ent(arr_ent), .err_held(err_cnt != '0),
        .pe(pe), .fe(fe), .bi(bi), .rx_err(rx_err)
    );

    lsr_tx_track u_tx (
        .clk(clk), .rst_n(rst_n), .wr_thr(thr_wr), .hold_empty(tx_hold_empty),
        .shift_empty(tx_shift_empty), .thre_ien(thre_irq_en),
        .thre(thre), .temt(temt), .irq_thre(thre_irq)
    );

    // Assemble the host-visible status byte.
    always_comb begin
        lsr_q          = '0;
        lsr_q[B_DR]    = (count != '0);
        lsr_q[B_OE]    = 1'b0;
        lsr_q[B_PE]    = pe;
        lsr_q[B_FE]    = fe;
        lsr_q[B_BI]    = bi;
        lsr_q[B_THRE]  = thre;
        lsr_q[B_TEMT]  = temt;
        lsr_q[B_RXERR] = rx_err;
    end

    assign rbr_q  = head_ent.data;
    assign ls_irq = ls_irq_en && (pe || fe || bi);

    // R2
    dr_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push && !lsr_q[B_DR]) |=> lsr_q[B_DR]);
    // R11
    ls_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ls_irq |-> ls_irq_en && (lsr_q[4:1] != 4'b0));
endmodule

// File: tb/uart_line_status_tb.sv
`timescale 1ns/1ps
module uart_line_status_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fifo_mode = 1'b1;
    logic       lsr_rd = 0, rbr_rd = 0, thr_wr = 0, rx_push = 0;
    logic [7:0] rx_data = 0;
    logic       rx_par_err = 0, rx_frm_err = 0, rx_brk = 0;
    logic       tx_hold_empty = 1, tx_shift_empty = 1;
    logic       ls_irq_en = 0, thre_irq_en = 0;
    logic [7:0] lsr_q, rbr_q;
    logic       ls_irq, thre_irq;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    uart_line_status #(.DEPTH(16)) u_dut (
        .clk(clk), .rst_n(rst_n), .fifo_mode(fifo_mode), .lsr_rd(lsr_rd),
        .rbr_rd(rbr_rd), .thr_wr(thr_wr), .rx_push(rx_push), .rx_data(rx_data),
        .rx_par_err(rx_par_err), .rx_frm_err(rx_frm_err), .rx_brk(rx_brk),
        .tx_hold_empty(tx_hold_empty), .tx_shift_empty(tx_shift_empty),
        .ls_irq_en(ls_irq_en), .thre_irq_en(thre_irq_en),
        .lsr_q(lsr_q), .rbr_q(rbr_q), .ls_irq(ls_irq), .thre_irq(thre_irq)
    );

    typedef struct packed {
        logic       push;
        logic [7:0] d;
        logic       pe, fe, bi, rd_rbr, rd_lsr;
        logic [7:0] exp_lsr, exp_rbr;
        logic [7:0] req;
    } vec_t;

    // FIFO-mode walk; status after each row's clock edge (R2 R3 R5 R6 R8).
    localparam vec_t VEC [14] = '{
        '{1'b1, 8'hA5, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h61, 8'hA5, 8'd2},
        '{1'b1, 8'h3C, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'hE1, 8'hA5, 8'd8},
        '{1'b1, 8'h7E, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'hE1, 8'hA5, 8'd5},
        '{1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'hE5, 8'h3C, 8'd5},
        '{1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'hE1, 8'h3C, 8'd6},
        '{1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'hE9, 8'h7E, 8'd5},
        '{1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'hE0, 8'h00, 8'd8},
        '{1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h60, 8'h00, 8'd8},
        '{1'b1, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'hF1, 8'h00, 8'd5},
        '{1'b1, 8'h11, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'hE1, 8'h00, 8'd6},
        '{1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'hE1, 8'h11, 8'd8},
        '{1'b1, 8'h22, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'hE5, 8'h22, 8'd5},
        '{1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'hE0, 8'h00, 8'd8},
        '{1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h60, 8'h00, 8'd6}
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    // Apply strobes over one edge, then release them just after it.
    task automatic step();
        @(posedge clk); #1;
        rx_push = 0; rbr_rd = 0; lsr_rd = 0; thr_wr = 0;
        rx_par_err = 0; rx_frm_err = 0; rx_brk = 0;
    endtask

    task automatic push(input logic [7:0] d, input logic p, input logic f, input logic b);
        rx_push = 1; rx_data = d; rx_par_err = p; rx_frm_err = f; rx_brk = b;
        step();
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin : main
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        #1;
        // R1 reset state
        chk("R1", lsr_q, 8'h60);
        chk("R1", rbr_q, 8'h00);
        chk("R1", {6'b0, ls_irq, thre_irq}, 8'h00);

        // Vector walk in FIFO mode
        for (int i = 0; i < 14; i++) begin
            rx_push = VEC[i].push; rx_data = VEC[i].d;
            rx_par_err = VEC[i].pe; rx_frm_err = VEC[i].fe; rx_brk = VEC[i].bi;
            rbr_rd = VEC[i].rd_rbr; lsr_rd = VEC[i].rd_lsr;
            step();
            chk($sformatf("R%0d row %0d lsr", VEC[i].req, i), lsr_q, VEC[i].exp_lsr);
            chk($sformatf("R%0d row %0d rbr", VEC[i].req, i), rbr_q, VEC[i].exp_rbr);
        end

        // R4 fill to 16, then a flagged push that must be dropped
        for (int i = 0; i < 16; i++) push(8'(i * 7 + 1), 0, 0, 0);
        chk("R2 full", lsr_q, 8'h61);
        push(8'hFF, 1, 0, 0);
        chk("R4 dropped status", lsr_q, 8'h61);
        // R3 order of delivery
        for (int i = 0; i < 16; i++) begin
            chk("R3 order", rbr_q, 8'(i * 7 + 1));
            rbr_rd = 1; step();
        end
        chk("R2 drained", lsr_q, 8'h60);
        chk("R3 empty rbr", rbr_q, 8'h00);

        // Holding mode
        fifo_mode = 0;
        push(8'h41, 1, 0, 0);
        chk("R5 holding immediate", lsr_q, 8'h65);
        chk("R7 overrun bit", {7'b0, lsr_q[1]}, 8'h00);
        chk("R8 holding summary", {7'b0, lsr_q[7]}, 8'h00);
        push(8'h42, 0, 0, 0);
        chk("R4 holding drop", rbr_q, 8'h41);
        lsr_rd = 1; step();
        chk("R6 read clears", lsr_q, 8'h61);
        rbr_rd = 1; step();
        chk("R2 holding empty", lsr_q, 8'h60);

        // R11 line-status interrupt
        ls_irq_en = 1;
        push(8'h50, 0, 1, 0);
        chk("R11 irq on", {7'b0, ls_irq}, 8'h01);
        chk("R5 framing", lsr_q, 8'h69);
        lsr_rd = 1; rbr_rd = 1; step();
        chk("R11 irq off", {7'b0, ls_irq}, 8'h00);
        ls_irq_en = 0;
        push(8'h51, 0, 0, 1);
        chk("R11 disabled", {7'b0, ls_irq}, 8'h00);
        chk("R5 break", lsr_q, 8'h71);
        lsr_rd = 1; rbr_rd = 1; step();

        // R9 R10 R12 transmit side
        thre_irq_en = 1;
        thr_wr = 1; step();
        chk("R9 write clears THRE", {7'b0, lsr_q[5]}, 8'h00);
        chk("R10 write clears TEMT", {7'b0, lsr_q[6]}, 8'h00);
        tx_hold_empty = 0; tx_shift_empty = 0; step();
        tx_hold_empty = 1; #1;
        chk("R9 holding empty", {7'b0, lsr_q[5]}, 8'h01);
        chk("R10 shift busy", {7'b0, lsr_q[6]}, 8'h00);
        chk("R12 pulse", {7'b0, thre_irq}, 8'h01);
        step();
        chk("R12 one cycle", {7'b0, thre_irq}, 8'h00);
        tx_shift_empty = 1; #1;
        chk("R10 both empty", {7'b0, lsr_q[6]}, 8'h01);
        thre_irq_en = 0;
        thr_wr = 1; step();
        tx_hold_empty = 0; step();
        tx_hold_empty = 1; #1;
        chk("R12 disabled", {7'b0, thre_irq}, 8'h00);
        step();

        finish_run();
    end
endmodule